// File: doc/BRIEF.md
# Retriggerable One-Shot Event Shaper

This block turns a noisy, asynchronous digital trip signal into one clean, timed output event. The raw signal is synchronized and reduced to single-cycle rising-edge events. A blanking gate drops events during a programmable ignore window. The window is opened by a strobe or by the release of reset. Surviving events fire a one-shot timer that drives the output for a programmable number of cycles.

A mode pin chooses what happens to events that arrive while the pulse is running. In retriggerable mode they restart the timer. In non-retriggerable mode they are ignored. Once the pulse ends, a rearm lockout of programmable length refuses new events. An optional latch holds the output high from the first accepted event until an explicit clear.

All timing values are cycle counts on input ports, so they can be changed without rebuilding. The interface is plain control and status pins: nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `event_shaper`

## Requirements
- R1: The raw input passes through two synchronizer flops and then an edge detector. A low-to-high change on `trig_raw` is accepted, at the earliest, on the third rising clock edge after it. `shaped_out` goes high after that edge. An input held high produces one event only.
- R2: An accepted event drives `shaped_out` high for exactly `width_cyc` cycles, even when `trig_raw` was high for a single cycle.
- R3: With `retrig_en` = 0, an event arriving while the pulse is active is ignored, and the pulse keeps exactly `width_cyc` cycles.
- R4: With `retrig_en` = 1, an event accepted during the pulse restarts the timer. The output stays high until `width_cyc` cycles after the last accepted event.
- R5: After the pulse ends, events are ignored for `rearm_cyc` cycles. An event accepted on the first edge after that lockout starts a new pulse.
- R6: A `blank_go` strobe sampled on a clock edge loads `blank_cyc`. Events on the following `blank_cyc` clock edges are discarded. Detection then resumes without further action.
- R7: A `blank_go` strobe that arrives while the window is open restarts the window at its full length.
- R8: Release of `rst_n` opens a blanking window of `blank_cyc` cycles, exactly as a strobe on the first edge after release would.
- R9: With `hold_en` = 1, an event accepted while idle sets a hold flag that keeps `shaped_out` high until a clock edge samples `hold_clr` high.
- R10: A count of zero disables its stage. `width_cyc` = 0 produces no pulse. `rearm_cyc` = 0 skips the lockout. `blank_cyc` = 0 opens no window.
- R11: `busy` is high exactly while the block is in the pulse or rearm phase, and low otherwise, including while only the hold flag keeps the output high.
- R12: While `rst_n` is low, `shaped_out` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; its release opens a blanking window |
| trig_raw | input | 1 | Asynchronous raw trip signal |
| blank_go | input | 1 | Strobe that opens or restarts the blanking window |
| retrig_en | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| hold_en | input | 1 | 1 = accepted events set the hold flag |
| hold_clr | input | 1 | Clears the hold flag |
| width_cyc | input | CNT_W | Pulse length in cycles (0 disables) |
| blank_cyc | input | CNT_W | Blanking window length in cycles (0 disables) |
| rearm_cyc | input | CNT_W | Rearm lockout length in cycles (0 disables) |
| shaped_out | output | 1 | Shaped event output |
| busy | output | 1 | High during pulse or rearm |

## Verification
Some rules are checked by assertions on every cycle:
- the synchronized edge lasts a single cycle;
- a pulse only starts after a qualified event;
- no pulse starts out of the rearm phase or while blanking holds the idle timer;
- a zero width never yields a pulse;
- a set hold flag keeps the output high until the clear.

Exact pulse lengths, the retrigger extension, the rearm and blanking boundary edges, the window restart and the reset-opened window are counted cycle by cycle only in the bench's directed scenarios.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_REARM = 2'd2
  } es_state_e;
endpackage

// File: rtl/es_sync_edge.sv
module es_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic edge_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] shf;

  always_ff @(posedge clk) begin
    if (!rst_n) shf <= '0;
    else        shf <= {shf[LAST-1:0], raw_i};
  end

  // rising edge of the last synchronizer stage, compared with its delayed copy
  assign edge_o = shf[LAST-1] & ~shf[LAST];

  assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/es_blank_gate.sv
module es_blank_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             edge_i,
  output logic             qual_o,
  output logic             blanking_o
);
  logic [CNT_W-1:0] bcnt;
  logic             boot_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt      <= '0;
      boot_pend <= 1'b1;
    end else begin
      boot_pend <= 1'b0;
      if (start_i || boot_pend) bcnt <= len_i;
      else if (bcnt != '0)      bcnt <= bcnt - 1'b1;
    end
  end

  assign blanking_o = (bcnt != '0);
  assign qual_o     = edge_i & ~blanking_o;
endmodule

// File: rtl/es_pulse_core.sv
module es_pulse_core
  import es_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             retrig_i,
  input  logic             hold_en_i,
  input  logic             hold_clr_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] rearm_i,
  output logic             out_o,
  output logic             busy_o,
  output logic             pulse_o,
  output logic             held_o
);
  es_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             held;
  logic             width_ok;

  assign width_ok = (width_i != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ev_i && width_ok) begin
            state <= ST_PULSE;
            cnt   <= width_i - 1'b1;
          end
        end
        ST_PULSE: begin
          if (ev_i && retrig_i && width_ok) begin
            cnt <= width_i - 1'b1;
          end else if (cnt == '0) begin
            if (rearm_i != '0) begin
              state <= ST_REARM;
              cnt   <= rearm_i - 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REARM: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 held <= 1'b0;
    else if (hold_clr_i)                        held <= 1'b0;
    else if (hold_en_i && ev_i && state == ST_IDLE) held <= 1'b1;
  end

  assign pulse_o = (state == ST_PULSE);
  assign busy_o  = (state != ST_IDLE);
  assign held_o  = held;
  assign out_o   = pulse_o | held;

  assert_start_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(ev_i));
  assert_rearm_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REARM) |=> (state != ST_PULSE));
  assert_zero_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !width_ok) |=> !pulse_o);
endmodule

// File: rtl/event_shaper.sv
module event_shaper #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_raw,
  input  logic             blank_go,
  input  logic             retrig_en,
  input  logic             hold_en,
  input  logic             hold_clr,
  input  logic [CNT_W-1:0] width_cyc,
  input  logic [CNT_W-1:0] blank_cyc,
  input  logic [CNT_W-1:0] rearm_cyc,
  output logic             shaped_out,
  output logic             busy
);
  logic edge_ev, qual_ev, blanking, pulse_act, held;

  es_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(trig_raw), .edge_o(edge_ev));

  es_blank_gate #(.CNT_W(CNT_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .start_i(blank_go), .len_i(blank_cyc),
    .edge_i(edge_ev), .qual_o(qual_ev), .blanking_o(blanking));

  es_pulse_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ev_i(qual_ev), .retrig_i(retrig_en),
    .hold_en_i(hold_en), .hold_clr_i(hold_clr), .width_i(width_cyc),
    .rearm_i(rearm_cyc), .out_o(shaped_out), .busy_o(busy),
    .pulse_o(pulse_act), .held_o(held));

  assert_blank_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && !busy) |=> !$rose(pulse_act));
  assert_hold_keeps_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !hold_clr) |=> shaped_out);
endmodule

// File: tb/event_shaper_test.sv
module event_shaper_test;
  localparam int W = 16;
  localparam int N = 40;

  logic clk = 1'b0;
  logic rst_n, trig_raw, blank_go, retrig_en, hold_en, hold_clr;
  logic [W-1:0] width_cyc, blank_cyc, rearm_cyc;
  logic shaped_out, busy;

  logic raw_pat [0:N-1];
  logic stb_pat [0:N-1];
  logic clr_pat [0:N-1];
  logic out_h   [0:N-1];
  logic busy_h  [0:N-1];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  event_shaper #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw), .blank_go(blank_go),
    .retrig_en(retrig_en), .hold_en(hold_en), .hold_clr(hold_clr),
    .width_cyc(width_cyc), .blank_cyc(blank_cyc), .rearm_cyc(rearm_cyc),
    .shaped_out(shaped_out), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_pats();
    for (int i = 0; i < N; i++) begin
      raw_pat[i] = 1'b0; stb_pat[i] = 1'b0; clr_pat[i] = 1'b0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trig_raw = raw_pat[i]; blank_go = stb_pat[i]; hold_clr = clr_pat[i];
      out_h[i] = shaped_out; busy_h[i] = busy;
    end
    trig_raw = 1'b0; blank_go = 1'b0; hold_clr = 1'b0;
  endtask

  function automatic int first_high(input int n);
    for (int i = 0; i < n; i++) if (out_h[i]) return i;
    return -1;
  endfunction

  function automatic int count_high(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (out_h[i]) c++;
    return c;
  endfunction

  function automatic int count_busy(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (busy_h[i]) c++;
    return c;
  endfunction

  task automatic cfg(input int wd, input int bl, input int ra, input bit rt, input bit hd);
    width_cyc = W'(wd); blank_cyc = W'(bl); rearm_cyc = W'(ra);
    retrig_en = rt; hold_en = hd;
    clear_pats();
  endtask

  task automatic t_reset_state();
    chk(shaped_out == 1'b0, "R12 out in reset", shaped_out, 0);
    chk(busy == 1'b0, "R12 busy in reset", busy, 0);
  endtask

  task automatic t_single_cycle();
    cfg(5, 0, 0, 0, 0);
    raw_pat[0] = 1'b1;
    run(N);
    chk(first_high(N) == 3, "R1 latency", first_high(N), 3);
    chk(count_high(N) == 5, "R2 full width from 1-cycle input", count_high(N), 5);
    chk(count_busy(N) == 5, "R11 busy tracks pulse", count_busy(N), 5);
  endtask

  task automatic t_held_input();
    cfg(4, 0, 0, 1, 0);
    for (int i = 0; i < 20; i++) raw_pat[i] = 1'b1;
    run(N);
    chk(count_high(N) == 4, "R1 held input gives one event", count_high(N), 4);
  endtask

  task automatic t_retrig();
    cfg(6, 0, 0, 1, 0);
    raw_pat[0] = 1'b1; raw_pat[4] = 1'b1;
    run(N);
    chk(first_high(N) == 3, "R4 start", first_high(N), 3);
    chk(count_high(N) == 10, "R4 extended width", count_high(N), 10);
    chk(out_h[12] == 1'b1 && out_h[13] == 1'b0, "R4 end edge", out_h[13], 0);
  endtask

  task automatic t_nonretrig();
    cfg(6, 0, 0, 0, 0);
    raw_pat[0] = 1'b1; raw_pat[4] = 1'b1;
    run(N);
    chk(count_high(N) == 6, "R3 fixed width", count_high(N), 6);
    chk(out_h[8] == 1'b1 && out_h[9] == 1'b0, "R3 end edge", out_h[9], 0);
  endtask

  task automatic t_rearm_block();
    cfg(3, 0, 4, 0, 0);
    raw_pat[0] = 1'b1; raw_pat[7] = 1'b1;
    run(N);
    chk(count_high(N) == 3, "R5 event on last rearm edge ignored", count_high(N), 3);
    chk(count_busy(N) == 7, "R11 busy spans pulse+rearm", count_busy(N), 7);
    chk(busy_h[6] == 1'b1 && out_h[6] == 1'b0, "R11 busy in rearm, out low", busy_h[6], 1);
  endtask

  task automatic t_rearm_accept();
    cfg(3, 0, 4, 0, 0);
    raw_pat[0] = 1'b1; raw_pat[8] = 1'b1;
    run(N);
    chk(count_high(N) == 6, "R5 event after rearm accepted", count_high(N), 6);
    chk(out_h[11] == 1'b1 && out_h[10] == 1'b0, "R5 second pulse start", out_h[11], 1);
  endtask

  task automatic t_blank_drop();
    cfg(4, 5, 0, 0, 0);
    stb_pat[0] = 1'b1; raw_pat[3] = 1'b1;
    run(N);
    chk(count_high(N) == 0, "R6 event in window dropped", count_high(N), 0);
  endtask

  task automatic t_blank_resume();
    cfg(4, 5, 0, 0, 0);
    stb_pat[0] = 1'b1; raw_pat[4] = 1'b1;
    run(N);
    chk(first_high(N) == 7, "R6 detection resumes after window", first_high(N), 7);
    chk(count_high(N) == 4, "R6 resumed pulse width", count_high(N), 4);
  endtask

  task automatic t_blank_restart();
    cfg(4, 5, 0, 0, 0);
    stb_pat[0] = 1'b1; stb_pat[3] = 1'b1; raw_pat[6] = 1'b1;
    run(N);
    chk(count_high(N) == 0, "R7 restarted window drops event", count_high(N), 0);
    cfg(4, 5, 0, 0, 0);
    stb_pat[0] = 1'b1; stb_pat[3] = 1'b1; raw_pat[7] = 1'b1;
    run(N);
    chk(first_high(N) == 10, "R7 restarted window end", first_high(N), 10);
  endtask

  task automatic t_reset_blank();
    cfg(4, 4, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    raw_pat[0] = 1'b1; raw_pat[5] = 1'b1;
    run(N);
    chk(first_high(N) == 8, "R8 reset release opens window", first_high(N), 8);
    chk(count_high(N) == 4, "R8 only post-window event fires", count_high(N), 4);
    blank_cyc = '0;
  endtask

  task automatic t_hold();
    cfg(3, 0, 0, 0, 1);
    raw_pat[0] = 1'b1; clr_pat[12] = 1'b1;
    run(N);
    chk(out_h[3] == 1'b1 && out_h[12] == 1'b1, "R9 held high", out_h[12], 1);
    chk(out_h[13] == 1'b0, "R9 cleared by hold_clr", out_h[13], 0);
    chk(count_busy(N) == 3, "R11 busy ignores hold flag", count_busy(N), 3);
    hold_en = 1'b0;
  endtask

  task automatic t_zero_width();
    cfg(0, 0, 0, 0, 0);
    raw_pat[0] = 1'b1;
    run(N);
    chk(count_high(N) == 0, "R10 zero width gives no pulse", count_high(N), 0);
    chk(count_busy(N) == 0, "R10 zero width never busy", count_busy(N), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_raw = 1'b0; blank_go = 1'b0; hold_clr = 1'b0;
    cfg(5, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_single_cycle();
    t_held_input();
    t_retrig();
    t_nonretrig();
    t_rearm_block();
    t_rearm_accept();
    t_blank_drop();
    t_blank_resume();
    t_blank_restart();
    t_reset_blank();
    t_hold();
    t_zero_width();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule